// File: doc/BRIEF.md
# Serial Nonvolatile Memory Command Controller

This block is the command side of a 512-byte serial memory with a watchdog-setting status field. A host talks to it over a mode-0 SPI link: a chip-select that is active low, a serial clock, a data input sampled on the rising clock edge and a data output that changes after the falling edge. Every opcode, address and data byte is sent most significant bit first. The memory itself is an on-chip register array. Program time is modelled by a counter that keeps the block busy for a set number of system clocks.

All serial pins are brought into the system clock domain through synchronizer stages. A single state record decodes opcodes and collects up to four data bytes for a page write. It also holds the write-enable latch, the protection level and the watchdog code, and it runs the busy counter. A write-protect input and a protection level stop writes. The protection level locks the top quarter, the top half or the whole array. The two-bit watchdog code is sent out to a supervisor block.

Top module: `eep_spi_ctrl`

## Requirements
- R1: The data output enable `so_oe` is 0 whenever the synchronized chip-select is high, and it is 1 while chip-select is low after the block is armed.
- R2: After reset, no command is accepted until chip-select has been seen falling. A WREN sent while chip-select was already low at reset leaves the latch clear.
- R3: RDSR (0x05) returns the status byte MSB first: bits 7:6 are 0, bits 5:4 are the watchdog code, bits 3:2 are the protection level, bit 1 is the write-enable latch, and bit 0 is busy. When idle, bit 0 reads 0. The status byte is loaded again for every further byte clocked out.
- R4: WREN (0x06) sets the write-enable latch and WRDI (0x04) clears it.
- R5: READ is the opcode 0000_A011, where A is address bit 8, followed by one byte holding address bits 7:0. Data comes out from that address, and the address steps up by one per byte, wrapping from 0x1FF to 0x000.
- R6: WRITE is the opcode 0000_A010, followed by an address byte and data bytes. It changes the array only when the latch was set at the rising edge of chip-select. Without the latch, the array is left unchanged.
- R7: Page-write data bytes go to consecutive addresses that wrap inside their aligned 4-byte page. A fifth byte replaces the slot of the first byte.
- R8: A write or status write starts only on the rising edge of chip-select, and only after a whole number of bytes. A partial final byte cancels it, and the latch stays set.
- R9: From the start of a write until it ends, `WR_CYCLES` clocks later, RDSR returns 0xFF and every other opcode is ignored. When the write completes, the write-enable latch is cleared.
- R10: Protection level 01 locks 0x180–0x1FF, 10 locks 0x100–0x1FF and 11 locks the whole array. A write into a locked range starts no cycle, leaves the data and the latch unchanged, and reads still work.
- R11: While `wp_n` is low, the latch is held clear and no write starts. Dropping `wp_n` before chip-select rises cancels the pending write. Dropping it during a running write cycle has no effect.
- R12: WRSR (0x01) followed by one byte stores bits 5:2 of that byte as the watchdog code and protection level when its write cycle completes. `wd_code` changes only at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Chip-select, active low |
| si | input | 1 | Serial data into the block |
| wp_n | input | 1 | Write protect, active low |
| so_o | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for the SO pad (0 = high impedance) |
| wd_code | output | 2 | Watchdog interval code sent to the supervisor |

## Verification
A latch or busy flag that holds the wrong value shows up in the next status read. It appears as a wrong bit 1 or bit 0 within one byte time of the opcode. It also shows up later: a data read-back differs once the write cycle would have finished. A wrong page slot or a wrong protection decode only appears when a later READ is compared byte by byte with the bench's own model of the array. A wrong watchdog code reaches `wd_code` on the clock where the status-write cycle ends.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [2:0] {
        PH_OPC,
        PH_ADDR,
        PH_WDAT,
        PH_RDAT,
        PH_SDAT,
        PH_WSR,
        PH_SKIP
    } phase_e;

    localparam logic [7:0] OP_WRSR    = 8'h01;
    localparam logic [7:0] OP_WRDI    = 8'h04;
    localparam logic [7:0] OP_RDSR    = 8'h05;
    localparam logic [7:0] OP_WREN    = 8'h06;
    localparam logic [7:0] OP_RW_MASK = 8'hF7;
    localparam logic [7:0] OP_WRITE   = 8'h02;
    localparam logic [7:0] OP_READ    = 8'h03;

    // quarter is the top two address bits
    function automatic logic quarter_locked(input logic [1:0] lvl, input logic [1:0] quarter);
        case (lvl)
            2'b01:   quarter_locked = (quarter == 2'b11);
            2'b10:   quarter_locked = quarter[1];
            2'b11:   quarter_locked = 1'b1;
            default: quarter_locked = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] lvl
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign lvl = stg[STAGES-1];
endmodule

// File: rtl/eep_array.sv
module eep_array #(
    parameter int AW    = 9,
    parameter int PORTS = 4,
    localparam int DEPTH = 1 << AW
) (
    input  logic                      clk,
    input  logic [PORTS-1:0]          we,
    input  logic [PORTS-1:0][AW-1:0]  waddr,
    input  logic [PORTS-1:0][7:0]     wdata,
    input  logic [AW-1:0]             raddr,
    output logic [7:0]                rdata
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        for (int p = 0; p < PORTS; p++) begin
            if (we[p]) cells[waddr[p]] <= wdata[p];
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/eep_spi_ctrl.sv
module eep_spi_ctrl
    import eep_pkg::*;
#(
    parameter int PAGE      = 4,
    parameter int WR_CYCLES = 64,
    parameter int SYNC      = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       cs_n,
    input  logic       si,
    input  logic       wp_n,
    output logic       so_o,
    output logic       so_oe,
    output logic [1:0] wd_code
);
    localparam int ADDR_W = 9;
    localparam int PG_W   = $clog2(PAGE);
    localparam int CNT_W  = $clog2(WR_CYCLES);

    typedef struct packed {
        phase_e                 phase;
        logic                   armed;
        logic                   sck_p;
        logic                   cs_p;
        logic [2:0]             bitcnt;
        logic [7:0]             shreg;
        logic                   a8;
        logic                   rd;
        logic [ADDR_W-1:0]      addr;
        logic [PG_W-1:0]        ncnt;
        logic [PAGE-1:0]        pval;
        logic [PAGE-1:0][7:0]   pbuf;
        logic                   sr_got;
        logic [3:0]             sr_new;
        logic                   wel;
        logic [1:0]             bp;
        logic [1:0]             wd;
        logic                   busy;
        logic                   wsr_op;
        logic [CNT_W-1:0]       bcnt;
        logic [7:0]             txsr;
        logic                   so;
    } st_t;

    st_t st_d, st_q;

    logic sck_s, cs_s, si_s, wp_s;
    eep_sync #(.WIDTH(4), .STAGES(SYNC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({sck, cs_n, si, wp_n}),
        .lvl   ({sck_s, cs_s, si_s, wp_s})
    );

    logic [ADDR_W-1:0]             rd_addr;
    logic [7:0]                    rd_data;
    logic [PAGE-1:0]               mem_we;
    logic [PAGE-1:0][ADDR_W-1:0]   mem_waddr;

    for (genvar s = 0; s < PAGE; s++) begin : g_port
        assign mem_waddr[s] = {st_q.addr[ADDR_W-1:PG_W], PG_W'(s)};
    end

    eep_array #(.AW(ADDR_W), .PORTS(PAGE)) u_array (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (st_q.pbuf),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    logic       sck_rise, sck_fall, cs_fall, cs_rise, active;
    logic [7:0] sh_next, status;
    logic [PG_W-1:0] slot;

    assign sck_rise = sck_s & ~st_q.sck_p;
    assign sck_fall = ~sck_s & st_q.sck_p;
    assign cs_fall  = ~cs_s & st_q.cs_p;
    assign cs_rise  = cs_s & ~st_q.cs_p;
    assign active   = st_q.armed & ~cs_s;
    assign sh_next  = {st_q.shreg[6:0], si_s};
    assign status   = st_q.busy ? 8'hFF : {2'b00, st_q.wd, st_q.bp, st_q.wel, 1'b0};
    assign rd_addr  = (st_q.phase == PH_ADDR) ? {st_q.a8, sh_next} : st_q.addr + 1'b1;
    assign slot     = st_q.addr[PG_W-1:0] + st_q.ncnt;

    always_comb begin
        st_d       = st_q;
        mem_we     = '0;
        st_d.sck_p = sck_s;
        st_d.cs_p  = cs_s;

        // internal write cycle
        if (st_q.busy) begin
            if (st_q.bcnt == '0) begin
                st_d.busy = 1'b0;
                st_d.wel  = 1'b0;
                if (st_q.wsr_op) {st_d.wd, st_d.bp} = st_q.sr_new;
                else             mem_we = st_q.pval;
            end else begin
                st_d.bcnt = st_q.bcnt - 1'b1;
            end
        end

        if (cs_fall) begin
            st_d.armed  = 1'b1;
            st_d.phase  = PH_OPC;
            st_d.bitcnt = '0;
            if (!st_q.busy) begin
                st_d.pval   = '0;
                st_d.ncnt   = '0;
                st_d.sr_got = 1'b0;
            end
        end else if (active && sck_rise) begin
            st_d.shreg  = sh_next;
            st_d.bitcnt = st_q.bitcnt + 1'b1;
            if (st_q.bitcnt == 3'd7) begin
                unique case (st_q.phase)
                    PH_OPC: begin
                        st_d.phase = PH_SKIP;
                        if (st_q.busy) begin
                            if (sh_next == OP_RDSR) begin
                                st_d.txsr  = status;
                                st_d.phase = PH_SDAT;
                            end
                        end else if (sh_next == OP_WREN) begin
                            st_d.wel = wp_s;
                        end else if (sh_next == OP_WRDI) begin
                            st_d.wel = 1'b0;
                        end else if (sh_next == OP_RDSR) begin
                            st_d.txsr  = status;
                            st_d.phase = PH_SDAT;
                        end else if (sh_next == OP_WRSR) begin
                            st_d.phase = PH_WSR;
                        end else if ((sh_next & OP_RW_MASK) == OP_READ ||
                                     (sh_next & OP_RW_MASK) == OP_WRITE) begin
                            st_d.a8    = sh_next[3];
                            st_d.rd    = sh_next[0];
                            st_d.phase = PH_ADDR;
                        end
                    end
                    PH_ADDR: begin
                        st_d.addr = {st_q.a8, sh_next};
                        if (st_q.rd) begin
                            st_d.txsr  = rd_data;
                            st_d.phase = PH_RDAT;
                        end else begin
                            st_d.phase = PH_WDAT;
                        end
                    end
                    PH_WDAT: begin
                        st_d.pbuf[slot] = sh_next;
                        st_d.pval[slot] = 1'b1;
                        st_d.ncnt       = st_q.ncnt + 1'b1;
                    end
                    PH_WSR: begin
                        st_d.sr_new = sh_next[5:2];
                        st_d.sr_got = 1'b1;
                        st_d.phase  = PH_SKIP;
                    end
                    default: ;
                endcase
            end
        end else if (active && sck_fall &&
                     (st_q.phase == PH_RDAT || st_q.phase == PH_SDAT)) begin
            st_d.so   = st_q.txsr[7];
            st_d.txsr = {st_q.txsr[6:0], 1'b0};
            if (st_q.bitcnt == 3'd7) begin
                if (st_q.phase == PH_RDAT) begin
                    st_d.addr = rd_addr;
                    st_d.txsr = rd_data;
                end else begin
                    st_d.txsr = status;
                end
            end
        end else if (cs_rise && st_q.armed) begin
            st_d.phase = PH_SKIP;
            if (!st_q.busy && st_q.bitcnt == '0 && st_q.wel && wp_s) begin
                if (st_q.phase == PH_WDAT && |st_q.pval &&
                    !quarter_locked(st_q.bp, st_q.addr[ADDR_W-1 -: 2])) begin
                    st_d.busy   = 1'b1;
                    st_d.wsr_op = 1'b0;
                    st_d.bcnt   = CNT_W'(WR_CYCLES - 1);
                end else if (st_q.sr_got) begin
                    st_d.busy   = 1'b1;
                    st_d.wsr_op = 1'b1;
                    st_d.bcnt   = CNT_W'(WR_CYCLES - 1);
                end
            end
        end

        if (!wp_s) st_d.wel = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_SKIP;
        end else begin
            st_q <= st_d;
        end
    end

    assign so_o    = st_q.so;
    assign so_oe   = st_q.armed & ~cs_s;
    assign wd_code = st_q.wd;

    logic armed_w, wel_w, busy_w;
    assign armed_w = st_q.armed;
    assign wel_w   = st_q.wel;
    assign busy_w  = st_q.busy;
endmodule

// File: rtl/eep_spi_chk.sv
module eep_spi_chk #(
    parameter int PAGE = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cs_s,
    input logic            wp_s,
    input logic            armed,
    input logic            so_oe,
    input logic            wel,
    input logic            wip,
    input logic [1:0]      wd_code,
    input logic [PAGE-1:0] mem_we
);
    // R1
    so_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |-> !so_oe);

    // R2
    unarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (!so_oe && !wel));

    // R11
    wp_clears_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_s |=> !wel);

    // R9
    write_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|mem_we) |-> wip);

    // R9
    wel_after_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> !wel);

    // R12
    wd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wip |=> $stable(wd_code));
endmodule

bind eep_spi_ctrl eep_spi_chk #(.PAGE(PAGE)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_s    (cs_s),
    .wp_s    (wp_s),
    .armed   (armed_w),
    .so_oe   (so_oe),
    .wel     (wel_w),
    .wip     (busy_w),
    .wd_code (wd_code),
    .mem_we  (mem_we)
);

// File: tb/eep_spi_ctrl_tb.sv
module eep_spi_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int WRC        = 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b0, si = 1'b0, wp_n = 1'b1;
    logic so_o, so_oe;
    logic [1:0] wd_code;
    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eep_spi_ctrl #(.PAGE(4), .WR_CYCLES(WRC), .SYNC(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .wp_n(wp_n), .so_o(so_o), .so_oe(so_oe), .wd_code(wd_code)
    );

    // address/data pairs, written then read back
    localparam logic [16:0] VEC [6] = '{
        {9'h000, 8'hA5}, {9'h1FF, 8'h5A}, {9'h123, 8'h3C},
        {9'h0FF, 8'hC3}, {9'h100, 8'h81}, {9'h07E, 8'h7E}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            si = tx[i];
            idle(HALF);
            rx[i] = so_o;
            sck = 1'b1;
            idle(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic cs_lo();
        @(negedge clk) cs_n = 1'b0;
        idle(HALF);
    endtask

    task automatic cs_hi();
        @(negedge clk) cs_n = 1'b1;
        idle(2*HALF);
    endtask

    task automatic cmd(input logic [7:0] op);
        logic [7:0] r;
        cs_lo(); xfer(op, r); cs_hi();
    endtask

    task automatic rdsr(output logic [7:0] v);
        logic [7:0] r;
        cs_lo(); xfer(8'h05, r); xfer(8'h00, v); cs_hi();
    endtask

    task automatic wait_idle();
        logic [7:0] v;
        for (int k = 0; k < 40; k++) begin
            rdsr(v);
            if (!v[0]) break;
        end
    endtask

    task automatic wr_start(input logic [8:0] a, input logic [7:0] d);
        logic [7:0] r;
        cs_lo(); xfer({4'b0000, a[8], 3'b010}, r); xfer(a[7:0], r); xfer(d, r);
    endtask

    task automatic wr(input logic [8:0] a, input logic [7:0] d);
        wr_start(a, d); cs_hi();
    endtask

    task automatic wrsr(input logic [7:0] d);
        logic [7:0] r;
        cmd(8'h06);
        cs_lo(); xfer(8'h01, r); xfer(d, r); cs_hi();
        wait_idle();
    endtask

    task automatic rd2(input logic [8:0] a, output logic [7:0] b0, output logic [7:0] b1);
        logic [7:0] r;
        cs_lo(); xfer({4'b0000, a[8], 3'b011}, r); xfer(a[7:0], r);
        xfer(8'h00, b0); xfer(8'h00, b1); cs_hi();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v, b0, b1, r;
        idle(5);
        rst_n = 1'b1;
        idle(5);
        // reset state
        chk("R1 reset so_oe", {7'd0, so_oe}, 8'h00);
        chk("R12 reset wd_code", {6'd0, wd_code}, 8'h00);
        // R2: chip-select already low at reset, WREN must not be taken
        xfer(8'h06, r);
        cs_hi();
        chk("R1 so_oe with cs high", {7'd0, so_oe}, 8'h00);
        cs_lo();
        chk("R1 so_oe with cs low", {7'd0, so_oe}, 8'h01);
        xfer(8'h05, r); xfer(8'h00, v); cs_hi();
        chk("R2 status after unarmed WREN", v, 8'h00);

        // R4 / R3
        cmd(8'h06); rdsr(v); chk("R4 WREN sets latch", v, 8'h02);
        cs_lo(); xfer(8'h05, r); xfer(8'h00, v); xfer(8'h00, b0); cs_hi();
        chk("R3 repeated status byte", b0, 8'h02);
        cmd(8'h04); rdsr(v); chk("R4 WRDI clears latch", v, 8'h00);

        // R5/R6 table of single writes, then read-back
        for (int i = 0; i < 6; i++) begin
            cmd(8'h06);
            wr(VEC[i][16:8], VEC[i][7:0]);
            wait_idle();
        end
        for (int i = 0; i < 6; i++) begin
            rd2(VEC[i][16:8], b0, b1);
            chk("R6 table read-back", b0, VEC[i][7:0]);
        end
        rd2(9'h1FF, b0, b1);
        chk("R5 read at top", b0, 8'h5A);
        chk("R5 read wraps to zero", b1, 8'hA5);
        rdsr(v); chk("R9 latch cleared after write", v, 8'h00);

        // R7 page write of five bytes starting at 0x0A1
        cmd(8'h06);
        wr_start(9'h0A1, 8'hD0);
        xfer(8'hD1, r); xfer(8'hD2, r); xfer(8'hD3, r); xfer(8'hD4, r);
        cs_hi(); wait_idle();
        rd2(9'h0A0, b0, b1);
        chk("R7 slot0", b0, 8'hD3);
        chk("R7 slot1 overwritten", b1, 8'hD4);
        rd2(9'h0A2, b0, b1);
        chk("R7 slot2", b0, 8'hD1);
        chk("R7 slot3", b1, 8'hD2);

        // R6 write without latch
        cmd(8'h06); wr(9'h070, 8'h20); wait_idle();
        wr(9'h070, 8'hEE);
        rdsr(v); chk("R6 no cycle without latch", v, 8'h00);
        rd2(9'h070, b0, b1); chk("R6 data unchanged", b0, 8'h20);

        // R8 partial final byte
        cmd(8'h06);
        wr_start(9'h070, 8'h99);
        for (int i = 0; i < 3; i++) begin
            si = 1'b1; idle(HALF); sck = 1'b1; idle(HALF); sck = 1'b0;
        end
        cs_hi();
        rdsr(v); chk("R8 partial byte starts nothing", v, 8'h02);
        rd2(9'h070, b0, b1); chk("R8 data unchanged", b0, 8'h20);
        cmd(8'h04);

        // R9 busy behaviour
        cmd(8'h06); wr(9'h051, 8'h44); wait_idle();
        cmd(8'h06); wr(9'h050, 8'h11);
        rdsr(v); chk("R9 status all ones while busy", v, 8'hFF);
        wr(9'h051, 8'h99);
        wait_idle();
        rdsr(v); chk("R9 idle after cycle", v, 8'h00);
        rd2(9'h050, b0, b1);
        chk("R9 first write landed", b0, 8'h11);
        chk("R9 write during busy ignored", b1, 8'h44);

        // R11 write protect
        cmd(8'h06); wr(9'h061, 8'h10); wait_idle();
        wp_n = 1'b0; idle(4);
        cmd(8'h06); rdsr(v); chk("R11 WREN blocked by wp", v, 8'h00);
        wp_n = 1'b1; idle(4);
        cmd(8'h06);
        wr_start(9'h061, 8'h55);
        wp_n = 1'b0; idle(4*HALF); wp_n = 1'b1; idle(4);
        cs_hi();
        rdsr(v); chk("R11 wp drop cancels pending", v, 8'h00);
        rd2(9'h061, b0, b1); chk("R11 cancelled data", b0, 8'h10);
        cmd(8'h06); wr(9'h060, 8'h77);
        wp_n = 1'b0; wait_idle(); wp_n = 1'b1; idle(4);
        rd2(9'h060, b0, b1); chk("R11 wp during cycle no effect", b0, 8'h77);

        // R10 protection levels
        cmd(8'h06); wr(9'h190, 8'h11); wait_idle();
        cmd(8'h06); wr(9'h010, 8'h01); wait_idle();
        wrsr(8'h04);
        rdsr(v); chk("R10 level 01 in status", v, 8'h04);
        cmd(8'h06); wr(9'h190, 8'h22);
        rdsr(v); chk("R10 locked write starts nothing", v, 8'h06);
        rd2(9'h190, b0, b1); chk("R10 locked data kept", b0, 8'h11);
        wr(9'h0F0, 8'h33); wait_idle();
        rd2(9'h0F0, b0, b1); chk("R10 unlocked quarter writable", b0, 8'h33);
        wrsr(8'h0C);
        cmd(8'h06); wr(9'h010, 8'h55);
        rdsr(v); chk("R10 full lock", v, 8'h0E);
        rd2(9'h010, b0, b1); chk("R10 full lock data kept", b0, 8'h01);

        // R12 watchdog code
        chk("R12 wd before", {6'd0, wd_code}, 8'h00);
        wrsr(8'h30);
        chk("R12 wd after status write", {6'd0, wd_code}, 8'h03);
        rdsr(v); chk("R3 status layout", v, 8'h30);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule